// File: doc/BRIEF.md
# Flash Access Protection Controller

This block sits in front of an on-chip flash array and rules on every access before it reaches the cells. Requests come from the CPU (instruction fetch, data read, byte write, sector erase) or from a debug port (read, write, erase). The block holds a small program-store control register with a write-enable bit, an erase-enable bit and a scratchpad-select bit. It also keeps shadow copies of two lock bytes that live inside the flash itself: one for read protection and one for write/erase protection. The shadows are loaded by a short read sequence after reset and kept current as the lock bytes are rewritten.

Each accepted request produces, one cycle later, a single-cycle grant or deny pulse. The pulse carries a translated physical address whose top bit selects a separate 128-byte scratchpad sector. When the scratchpad is selected, this sector is laid over CPU addresses 0x00–0x7F. Reads and fetches also return a data beat one cycle after the decision. A denied read returns a fixed filler byte instead of array contents. Any deny raises a sticky violation flag that software clears by writing 1 to bit 7 of the control register.

Top module: `flash_prot_ctrl`

## Requirements
- R1: After reset release the block reads address 0xFDFE (write/erase lock) and then 0xFDFF (read lock) through its lock port. It holds ready_o low until both values are captured. ready_o rises on the third clock edge after release and then stays high.
- R2: Each request taken while ready_o is high produces exactly one of gnt_o and dny_o, for one cycle, on the next clock. op_o, wdata_o and phys_addr_o are valid in that same cycle. The op encoding is 0 fetch, 1 read, 2 write, 3 erase. src_dbg_i=1 marks a debug-port request.
- R3: A CPU write is denied unless control bit 0 (write enable) is 1. A CPU erase is denied unless control bit 1 (erase enable) is 1.
- R4: A debug read is denied when bit addr[15:13] of the read-lock byte is 0. The denied read returns the filler byte 0xA5 on rdata_o.
- R5: A debug write or erase is denied when bit addr[15:13] of the write/erase-lock byte is 0. CPU accesses ignore both lock bytes.
- R6: With control bit 2 (scratchpad select) set, a CPU address below 0x80 maps to phys_addr_o = 0x10000 + addr[6:0]. Every other access, including all debug accesses, maps to phys_addr_o = addr with bit 16 clear.
- R7: A CPU fetch that maps to the scratchpad is denied. Every debug-port fetch is denied.
- R8: A CPU erase aimed at the lock sector 0xFC00–0xFDFF is denied. A CPU write into that sector is allowed when write enable is set.
- R9: Writes and erases from either source aimed at 0xFE00–0xFFFF are denied.
- R10: A granted write to 0xFDFE or 0xFDFF ANDs its data into the matching lock shadow. A granted erase of the lock sector sets both shadows to 0xFF. Later requests are judged with the updated value.
- R11: viol_o is set on every deny. It stays set until a control write with bit 7 equal to 1. If a deny and a clear happen in the same cycle, the deny wins.
- R12: Every fetch or read request raises rvld_o one cycle after its decision. On a grant, rdata_o then carries the array byte at phys_addr_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request strobe |
| src_dbg_i | input | 1 | 1 = debug port, 0 = CPU |
| op_i | input | 2 | Access kind: 0 fetch, 1 read, 2 write, 3 erase |
| addr_i | input | 16 | Logical flash address |
| wdata_i | input | 8 | Write data |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control write data: bit0 write enable, bit1 erase enable, bit2 scratch select, bit7 clear violation |
| ctl_o | output | 3 | Current control bits {scratch, erase en, write en} |
| viol_o | output | 1 | Sticky violation flag |
| ready_o | output | 1 | Lock shadows loaded; requests accepted |
| lk_rd_o | output | 1 | Lock byte read strobe to array |
| lk_addr_o | output | 16 | Lock byte read address |
| lk_data_i | input | 8 | Lock byte data, one cycle after strobe |
| gnt_o | output | 1 | Access granted pulse |
| dny_o | output | 1 | Access denied pulse |
| phys_addr_o | output | 17 | Translated address, bit 16 selects scratchpad |
| op_o | output | 2 | Access kind of the decided request |
| wdata_o | output | 8 | Write data of the decided request |
| arr_rdata_i | input | 8 | Array read data, one cycle after grant |
| rvld_o | output | 1 | Read data valid |
| rdata_o | output | 8 | Read data or filler |

## Verification
The assertions assume that the array returns a lock byte one cycle after the lock strobe and that no request arrives while ready_o is low. They also assume that the control register is not written in the same cycle as a request it is meant to govern. The bench holds to this by issuing requests and control writes in separate cycles, only after it has seen ready_o high. It spaces requests so that each decision and its data beat have finished before the next request starts.

// File: rtl/flash_prot_pkg.sv
package flash_prot_pkg;
  typedef enum logic [1:0] {
    OP_FETCH = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_ERASE = 2'd3
  } fp_op_e;

  typedef enum logic [1:0] {
    LD_WLOCK = 2'd0,
    LD_RLOCK = 2'd1,
    LD_CAP   = 2'd2,
    LD_RUN   = 2'd3
  } ld_state_e;

  localparam int CTL_WEN  = 0;
  localparam int CTL_EEN  = 1;
  localparam int CTL_SCR  = 2;
  localparam int CTL_VCLR = 7;
endpackage

// File: rtl/fp_ctl_reg.sv
module fp_ctl_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_we_i,
  input  logic [DATA_W-1:0] ctl_wdata_i,
  input  logic              set_viol_i,
  output logic              wen_o,
  output logic              een_o,
  output logic              scr_o,
  output logic              viol_o
);
  import flash_prot_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wen_o <= 1'b0;
      een_o <= 1'b0;
      scr_o <= 1'b0;
    end else if (ctl_we_i) begin
      wen_o <= ctl_wdata_i[CTL_WEN];
      een_o <= ctl_wdata_i[CTL_EEN];
      scr_o <= ctl_wdata_i[CTL_SCR];
    end
  end

  // set has priority over write-1-to-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  viol_o <= 1'b0;
    else if (set_viol_i)                          viol_o <= 1'b1;
    else if (ctl_we_i && ctl_wdata_i[CTL_VCLR])   viol_o <= 1'b0;
  end

  p_viol_set_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_viol_i |=> viol_o);
  p_viol_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_o && !(ctl_we_i && ctl_wdata_i[CTL_VCLR])) |=> viol_o);
endmodule

// File: rtl/fp_lock_shadow.sv
module fp_lock_shadow #(
  parameter int              ADDR_W     = 16,
  parameter int              DATA_W     = 8,
  parameter int              SECT_W     = 9,
  parameter logic [ADDR_W-1:0] WLOCK_ADDR = 16'hFDFE,
  parameter logic [ADDR_W-1:0] RLOCK_ADDR = 16'hFDFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] lk_data_i,
  input  logic              upd_wr_i,
  input  logic              upd_er_i,
  input  logic [ADDR_W-1:0] upd_addr_i,
  input  logic [DATA_W-1:0] upd_data_i,
  output logic              lk_rd_o,
  output logic [ADDR_W-1:0] lk_addr_o,
  output logic              ready_o,
  output logic [DATA_W-1:0] wlock_o,
  output logic [DATA_W-1:0] rlock_o
);
  import flash_prot_pkg::*;

  localparam int TAG_W = ADDR_W - SECT_W;

  ld_state_e st_q;
  logic      in_lock_sect;

  assign in_lock_sect = upd_addr_i[ADDR_W-1:SECT_W] == WLOCK_ADDR[ADDR_W-1:SECT_W];
  assign lk_rd_o      = (st_q == LD_WLOCK) || (st_q == LD_RLOCK);
  assign lk_addr_o    = (st_q == LD_WLOCK) ? WLOCK_ADDR : RLOCK_ADDR;
  assign ready_o      = (st_q == LD_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= LD_WLOCK;
    else if (st_q != LD_RUN) st_q <= ld_state_e'(st_q + 2'd1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wlock_o <= '0;
      rlock_o <= '0;
    end else begin
      if (st_q == LD_RLOCK) wlock_o <= lk_data_i;
      if (st_q == LD_CAP)   rlock_o <= lk_data_i;
      if (upd_er_i && in_lock_sect) begin
        wlock_o <= '1;
        rlock_o <= '1;
      end else if (upd_wr_i) begin
        if (upd_addr_i == WLOCK_ADDR) wlock_o <= wlock_o & upd_data_i;
        if (upd_addr_i == RLOCK_ADDR) rlock_o <= rlock_o & upd_data_i;
      end
    end
  end

  p_ready_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);
  p_wlock_and_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && upd_wr_i && !upd_er_i && upd_addr_i == WLOCK_ADDR)
      |=> ((wlock_o & ~$past(upd_data_i)) == '0));
  p_erase_open_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && upd_er_i && in_lock_sect) |=> (&wlock_o && &rlock_o));
endmodule

// File: rtl/fp_decide.sv
module fp_decide #(
  parameter int                ADDR_W     = 16,
  parameter int                DATA_W     = 8,
  parameter int                BLK_W      = 13,
  parameter int                SCR_W      = 7,
  parameter int                SECT_W     = 9,
  parameter logic [ADDR_W-1:0] RSV_BASE   = 16'hFE00,
  parameter logic [ADDR_W-1:0] WLOCK_ADDR = 16'hFDFE
) (
  input  logic              src_dbg_i,
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wen_i,
  input  logic              een_i,
  input  logic              scr_i,
  input  logic [DATA_W-1:0] wlock_i,
  input  logic [DATA_W-1:0] rlock_i,
  output logic              allow_o,
  output logic [ADDR_W:0]   phys_o
);
  import flash_prot_pkg::*;

  localparam int BLK_IDX_W = ADDR_W - BLK_W;

  logic [BLK_IDX_W-1:0] blk;
  logic scr_hit, rsv, lk_sect;

  assign blk     = addr_i[ADDR_W-1:BLK_W];
  assign scr_hit = !src_dbg_i && scr_i && (addr_i[ADDR_W-1:SCR_W] == '0);
  assign rsv     = addr_i >= RSV_BASE;
  assign lk_sect = addr_i[ADDR_W-1:SECT_W] == WLOCK_ADDR[ADDR_W-1:SECT_W];

  always_comb begin
    allow_o = 1'b0;
    if (src_dbg_i) begin
      unique case (fp_op_e'(op_i))
        OP_FETCH: allow_o = 1'b0;
        OP_READ:  allow_o = rlock_i[blk];
        default:  allow_o = wlock_i[blk] && !rsv;
      endcase
    end else begin
      unique case (fp_op_e'(op_i))
        OP_FETCH: allow_o = !scr_hit;
        OP_READ:  allow_o = 1'b1;
        OP_WRITE: allow_o = wen_i && (scr_hit || !rsv);
        default:  allow_o = een_i && (scr_hit || (!rsv && !lk_sect));
      endcase
    end
  end

  always_comb begin
    phys_o = {1'b0, addr_i};
    if (scr_hit) begin
      phys_o = '0;
      phys_o[ADDR_W] = 1'b1;
      phys_o[SCR_W-1:0] = addr_i[SCR_W-1:0];
    end
  end
endmodule

// File: rtl/flash_prot_ctrl.sv
module flash_prot_ctrl #(
  parameter int                ADDR_W     = 16,
  parameter int                DATA_W     = 8,
  parameter int                BLK_W      = 13,
  parameter int                SCR_W      = 7,
  parameter int                SECT_W     = 9,
  parameter logic [ADDR_W-1:0] RSV_BASE   = 16'hFE00,
  parameter logic [ADDR_W-1:0] WLOCK_ADDR = 16'hFDFE,
  parameter logic [ADDR_W-1:0] RLOCK_ADDR = 16'hFDFF,
  parameter logic [DATA_W-1:0] FILLER     = 8'hA5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              src_dbg_i,
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ctl_we_i,
  input  logic [DATA_W-1:0] ctl_wdata_i,
  output logic [2:0]        ctl_o,
  output logic              viol_o,
  output logic              ready_o,
  output logic              lk_rd_o,
  output logic [ADDR_W-1:0] lk_addr_o,
  input  logic [DATA_W-1:0] lk_data_i,
  output logic              gnt_o,
  output logic              dny_o,
  output logic [ADDR_W:0]   phys_addr_o,
  output logic [1:0]        op_o,
  output logic [DATA_W-1:0] wdata_o,
  input  logic [DATA_W-1:0] arr_rdata_i,
  output logic              rvld_o,
  output logic [DATA_W-1:0] rdata_o
);
  import flash_prot_pkg::*;

  localparam int PHYS_W = ADDR_W + 1;

  logic wen, een, scr, allow, accept, src_q, mask_q;
  logic [DATA_W-1:0] wlock, rlock;
  logic [PHYS_W-1:0] phys;

  assign accept = req_i && ready_o;
  assign ctl_o  = {scr, een, wen};

  fp_ctl_reg #(.DATA_W(DATA_W)) u_ctl (
    .clk_i, .rst_ni, .ctl_we_i, .ctl_wdata_i,
    .set_viol_i(accept && !allow),
    .wen_o(wen), .een_o(een), .scr_o(scr), .viol_o(viol_o)
  );

  fp_lock_shadow #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W),
    .WLOCK_ADDR(WLOCK_ADDR), .RLOCK_ADDR(RLOCK_ADDR)
  ) u_shadow (
    .clk_i, .rst_ni, .lk_data_i,
    .upd_wr_i(accept && allow && op_i == OP_WRITE),
    .upd_er_i(accept && allow && op_i == OP_ERASE && !phys[ADDR_W]),
    .upd_addr_i(addr_i), .upd_data_i(wdata_i),
    .lk_rd_o, .lk_addr_o, .ready_o,
    .wlock_o(wlock), .rlock_o(rlock)
  );

  fp_decide #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W), .SCR_W(SCR_W),
    .SECT_W(SECT_W), .RSV_BASE(RSV_BASE), .WLOCK_ADDR(WLOCK_ADDR)
  ) u_decide (
    .src_dbg_i, .op_i, .addr_i,
    .wen_i(wen), .een_i(een), .scr_i(scr),
    .wlock_i(wlock), .rlock_i(rlock),
    .allow_o(allow), .phys_o(phys)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_o       <= 1'b0;
      dny_o       <= 1'b0;
      phys_addr_o <= '0;
      op_o        <= '0;
      wdata_o     <= '0;
      src_q       <= 1'b0;
      rvld_o      <= 1'b0;
      mask_q      <= 1'b0;
    end else begin
      gnt_o  <= accept && allow;
      dny_o  <= accept && !allow;
      rvld_o <= (gnt_o || dny_o) && !op_o[1];
      mask_q <= dny_o;
      if (accept) begin
        phys_addr_o <= phys;
        op_o        <= op_i;
        wdata_o     <= wdata_i;
        src_q       <= src_dbg_i;
      end
    end
  end

  assign rdata_o = !rvld_o ? '0 : (mask_q ? FILLER : arr_rdata_i);

  p_gnt_dny_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gnt_o && dny_o));
  p_resp_has_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o || dny_o) |-> $past(req_i && ready_o));
  p_wr_needs_wen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o && op_o == OP_WRITE && !src_q) |-> $past(ctl_o[CTL_WEN]));
  p_filler_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvld_o && $past(dny_o)) |-> rdata_o == FILLER);
  p_no_scr_fetch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o && op_o == OP_FETCH) |-> !phys_addr_o[ADDR_W]);
  p_no_lock_erase_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o && op_o == OP_ERASE && !src_q)
      |-> (phys_addr_o[ADDR_W] || phys_addr_o[ADDR_W-1:SECT_W] != WLOCK_ADDR[ADDR_W-1:SECT_W]));
  p_no_rsv_mod_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o && op_o[1] && !phys_addr_o[ADDR_W]) |-> phys_addr_o[ADDR_W-1:0] < RSV_BASE);
  p_dny_flags_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dny_o |-> viol_o);
  p_rvld_follows_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvld_o |-> $past(gnt_o || dny_o));
endmodule

// File: tb/flash_prot_ctrl_bench.sv
`timescale 1ns/1ps
module flash_prot_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, src_dbg = 1'b0;
  logic [1:0]  op = '0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        ctl_we = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic [2:0]  ctl;
  logic        viol, ready, lk_rd, gnt, dny, rvld;
  logic [15:0] lk_addr;
  logic [7:0]  lk_data = '0, arr_rdata = '0, wdata_q, rdata;
  logic [16:0] phys;
  logic [1:0]  op_q;

  int total = 0, bad = 0;
  logic [7:0] mem [int];
  logic [2:0] m_ctl = '0;
  bit         m_viol = 0;

  always #4 clk = ~clk;

  flash_prot_ctrl u_flash_prot_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .src_dbg_i(src_dbg), .op_i(op),
    .addr_i(addr), .wdata_i(wdata), .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata),
    .ctl_o(ctl), .viol_o(viol), .ready_o(ready), .lk_rd_o(lk_rd),
    .lk_addr_o(lk_addr), .lk_data_i(lk_data), .gnt_o(gnt), .dny_o(dny),
    .phys_addr_o(phys), .op_o(op_q), .wdata_o(wdata_q),
    .arr_rdata_i(arr_rdata), .rvld_o(rvld), .rdata_o(rdata)
  );

  function automatic logic [7:0] rd(int k);
    return mem.exists(k) ? mem[k] : 8'hFF;
  endfunction

  // array model: acts on the granted pulse
  always @(posedge clk) begin
    if (lk_rd) lk_data <= rd(int'(lk_addr));
    if (gnt) begin
      if (op_q == 2'd2) mem[int'(phys)] = rd(int'(phys)) & wdata_q;
      else if (op_q == 2'd3) begin
        if (phys[16]) for (int i = 0; i < 128; i++) mem.delete(32'h10000 + i);
        else for (int i = 0; i < 512; i++) mem.delete(int'({phys[15:9], 9'd0}) + i);
      end
      arr_rdata <= rd(int'(phys));
    end
  end

  // reference model
  function automatic bit scr_map(bit dbg, logic [15:0] a);
    return !dbg && m_ctl[2] && a < 16'h0080;
  endfunction

  function automatic logic [16:0] ref_phys(bit dbg, logic [15:0] a);
    return scr_map(dbg, a) ? (17'h10000 + a) : {1'b0, a};
  endfunction

  function automatic bit ref_allow(bit dbg, logic [1:0] o, logic [15:0] a);
    int blk = a / 16'h2000;
    bit rsv = a >= 16'hFE00;
    bit lks = a >= 16'hFC00 && a <= 16'hFDFF;
    bit sc = scr_map(dbg, a);
    logic [7:0] wl = rd(32'hFDFE), rl = rd(32'hFDFF);
    if (dbg) begin
      if (o == 0) return 0;
      if (o == 1) return rl[blk];
      return wl[blk] && !rsv;
    end
    case (o)
      2'd0: return !sc;
      2'd1: return 1;
      2'd2: return m_ctl[0] && (sc || !rsv);
      default: return m_ctl[1] && (sc || (!rsv && !lks));
    endcase
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_req(bit dbg, logic [1:0] o, logic [15:0] a, logic [7:0] d, string tag);
    bit ok = ref_allow(dbg, o, a);
    logic [16:0] ph = ref_phys(dbg, a);
    logic [7:0] ed = ok ? rd(int'(ph)) : 8'hA5;
    if (!ok) m_viol = 1;
    req = 1; src_dbg = dbg; op = o; addr = a; wdata = d;
    @(negedge clk);
    req = 0;
    chk(gnt == ok && dny == !ok, {tag, " decision"}, {gnt, dny}, {ok, !ok});
    chk(phys == ph, {tag, " phys R6"}, phys, ph);
    chk(viol == m_viol, {tag, " viol R11"}, viol, m_viol);
    @(negedge clk);
    chk(!gnt && !dny, {tag, " single pulse R2"}, {gnt, dny}, 0);
    if (o < 2) chk(rvld && rdata == ed, {tag, " rdata R12"}, {rvld, rdata}, {1'b1, ed});
    @(negedge clk);
  endtask

  task automatic ctl_wr(logic [7:0] d, string tag);
    ctl_we = 1; ctl_wdata = d;
    @(negedge clk);
    ctl_we = 0;
    m_ctl = d[2:0];
    if (d[7]) m_viol = 0;
    chk(viol == m_viol && ctl == m_ctl, tag, {viol, ctl}, {m_viol, m_ctl});
    @(negedge clk);
  endtask

  initial begin
    #(8ns * 200000);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    mem[32'hFDFE] = 8'hEF;   // block 4 write-locked
    mem[32'hFDFF] = 8'hFB;   // block 2 read-locked
    mem[32'h4010] = 8'h3C;
    mem[32'h0005] = 8'h11;
    mem[32'h10005] = 8'h22;
    repeat (3) @(negedge clk);
    chk(!gnt && !dny && !viol && !ready && !rvld, "reset state R1", {gnt, dny, viol, ready}, 0);
    rst_n = 1;
    @(negedge clk); @(negedge clk);
    chk(!ready, "ready low during load R1", ready, 0);
    @(negedge clk);
    chk(ready, "ready after load R1", ready, 1);
    @(negedge clk);

    do_req(0, 1, 16'h4010, 0, "cpu read R12");
    do_req(0, 2, 16'h4010, 8'h0F, "cpu write no wen R3");
    ctl_wr(8'h81, "clear viol R11");
    do_req(0, 2, 16'h4010, 8'h0F, "cpu write R3");
    do_req(0, 1, 16'h4010, 0, "write clears bits R12");
    do_req(0, 3, 16'h4000, 0, "cpu erase no een R3");
    ctl_wr(8'h83, "clear viol erase en R11");
    do_req(0, 3, 16'h4000, 0, "cpu erase R3");
    do_req(0, 1, 16'h4010, 0, "erased reads FF R12");

    do_req(1, 1, 16'h4010, 0, "dbg read locked R4");
    do_req(1, 1, 16'h8000, 0, "dbg read open R4");
    do_req(1, 2, 16'h8000, 8'h00, "dbg write locked R5");
    do_req(1, 2, 16'h4020, 8'h5A, "dbg write open R5");
    do_req(0, 2, 16'h8000, 8'h77, "cpu ignores lock R5");
    do_req(0, 1, 16'h8000, 0, "cpu read locked-blk R5");

    ctl_wr(8'h87, "scratch on R6");
    do_req(0, 1, 16'h0005, 0, "scratch read R6");
    do_req(0, 0, 16'h0005, 0, "scratch fetch R7");
    do_req(1, 1, 16'h0005, 0, "dbg bypasses scratch R6");
    do_req(0, 1, 16'h0085, 0, "above scratch R6");
    do_req(0, 0, 16'h0100, 0, "main fetch R7");
    ctl_wr(8'h83, "scratch off R6");
    do_req(0, 1, 16'h0005, 0, "main low read R6");
    do_req(1, 0, 16'h1000, 0, "dbg fetch R7");

    do_req(0, 3, 16'hFC00, 0, "cpu erase lock sect R8");
    do_req(0, 2, 16'hFDFF, 8'hFF, "cpu write lock sect R8");
    do_req(0, 2, 16'hFE10, 8'h00, "cpu write rsv R9");
    do_req(1, 2, 16'hFE10, 8'h00, "dbg write rsv R9");
    do_req(0, 3, 16'hFE00, 0, "cpu erase rsv R9");

    do_req(1, 2, 16'hFDFE, 8'hDF, "dbg lock write R10");
    do_req(1, 2, 16'hA000, 8'h00, "new wlock applies R10");
    do_req(0, 2, 16'hFDFF, 8'hF7, "cpu rlock write R10");
    do_req(1, 1, 16'h6000, 0, "new rlock applies R10");
    do_req(1, 3, 16'hFC00, 0, "dbg erase lock sect R10");
    do_req(1, 1, 16'h4010, 0, "locks reopened R10");
    do_req(1, 2, 16'hA000, 8'h00, "wlock reopened R10");

    ctl_wr(8'h80, "final clear R11");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule